// File: doc/BRIEF.md
# Banked-Stack Control Register Bank

This block is the control-register bank of a processor core. A 4-bit register number selects one of its entries. The entries are:

- a 16-bit composite status register, made of a backup status byte and the live status byte;
- a second-level backup status byte;
- the condition bit;
- two banked stack-pointer slots, one for interrupts and one for user code;
- two backup program counters;
- two plain 32-bit scratch slots.

Reads are combinational from the read index. Every write, including the pointer exchange, lands on one rising clock edge.

The block also holds the live general-register stack pointer (register 15). The general register file updates it through a dedicated write port, and the block presents its value on `spLive`. Bit 7 of the status byte is the stack-mode bit. It decides which banked slot the live pointer currently stands in for. When a full-width status write flips that bit, the live pointer and the matching banked slot are exchanged in the same edge.

A narrow 8-bit port reads and writes only the status byte. It never exchanges stack pointers. Reset is synchronous, active high, and clears all state.

Top module: `ctrl_reg_bank`

## Requirements
- R1: While `rst` is high at a rising edge, all state clears. Afterwards every read index returns 0, `statRdData` is 0 and `spLive` is 0.
- R2: Index 0 (status) reads as a composite value. Bits 15:8 are the backup status byte AND 0xC1. Bits 7:6 are status bits 7:6. Bit 0 is the condition bit. Every other bit reads 0.
- R3: A write to index 0 loads the backup status byte from `wrData[15:8]` and the status byte from `wrData[7:0]`, and sets the condition bit from `wrData[0]`.
- R4: Index 1 reads the condition bit in bit 0, with the other bits zero. A write to index 1 sets the condition bit from `wrData[0]`.
- R5: Index 7 (second-level backup status) stores `wrData[7:0]` on a write and reads back the stored byte AND 0xC1.
- R6: Index 2 (interrupt stack pointer) reads and writes the live pointer when the stack-mode bit (status bit 7) is 0, and its own slot when the bit is 1. Index 3 (user stack pointer) does the opposite.
- R7: When a write to index 0 changes the stack-mode bit from 1 to 0, the live pointer is saved into the user slot and then reloaded from the interrupt slot. When the change is from 0 to 1, the live pointer is saved into the interrupt slot and then reloaded from the user slot. Writes that leave the mode bit unchanged do not touch the pointers.
- R8: Indices 6 and 8 (backup program counters) store all 32 bits on a write. On a read, bit 0 is forced to 0.
- R9: Indices 4 and 5 are plain 32-bit storage. Indices 9 to 15 read as 0, and writes to them change no state.
- R10: `statRdData` shows status bits 7:1 with bit 0 replaced by the condition bit. A `statWrEn` write stores the whole byte and copies bit 0 into the condition bit. It never exchanges stack pointers.
- R11: A `gprSpWe` write loads the live pointer unless the same edge's control-register write changes the live pointer. In that case the control-register path wins and the general-register data is dropped.
- R12: When `wrEn` and `statWrEn` are both high on one edge, only the full-width write takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| rdIdx | input | 4 | Read register number |
| rdData | output | 32 | Combinational read data |
| wrEn | input | 1 | Full-width write enable |
| wrIdx | input | 4 | Write register number |
| wrData | input | 32 | Write data |
| statWrEn | input | 1 | Status-byte port write enable |
| statWrData | input | 8 | Status-byte port write data |
| statRdData | output | 8 | Status byte with the condition bit in bit 0 |
| gprSpWe | input | 1 | General register file write to the live stack pointer |
| gprSpData | input | 32 | Data for that write |
| spLive | output | 32 | Live stack pointer (register 15) |

## Verification
A wrong stack-mode bit or a missed exchange stays invisible until a pointer is used. It then shows as the wrong value on `spLive`, or on `rdData` for index 2 or 3, on the edge after the status write. Such a fault can hide for many cycles unless a pointer index is read back. For that reason, every cycle the bench compares `rdData`, `statRdData` and `spLive` against a behavioural model. Directed sequences read each alias right after each mode flip. Corrupted masking of the status or backup-PC reads shows up in the same cycle as the read.

// File: rtl/ctrl_reg_pkg.sv
package ctrl_reg_pkg;
  localparam int IDX_W     = 4;
  localparam int GEN_SLOTS = 2;
  localparam int MODE_BIT  = 7;

  typedef logic [IDX_W-1:0] crIdx_t;

  localparam crIdx_t IDX_STATUS = 4'd0;
  localparam crIdx_t IDX_COND   = 4'd1;
  localparam crIdx_t IDX_SPI    = 4'd2;
  localparam crIdx_t IDX_SPU    = 4'd3;
  localparam crIdx_t IDX_GEN0   = 4'd4;
  localparam crIdx_t IDX_BPC    = 4'd6;
  localparam crIdx_t IDX_BBSTAT = 4'd7;
  localparam crIdx_t IDX_BBPC   = 4'd8;

  localparam logic [7:0] BACKUP_MASK = 8'hC1;
  localparam logic [7:0] STAT_MASK   = 8'hC0;

  typedef struct packed {
    logic                 ldStatus;
    logic                 ldStatusByte;
    logic                 ldCond;
    logic                 ldBbStat;
    logic                 ldSpiSlot;
    logic                 ldSpuSlot;
    logic                 ldLiveFromBus;
    logic                 ldBpc;
    logic                 ldBbpc;
    logic [GEN_SLOTS-1:0] ldGen;
    logic                 swapEnterIntr;
    logic                 swapEnterUser;
    logic                 ldLiveFromGpr;
  } crStrobe_t;
endpackage

// File: rtl/ctrl_reg_ctrl.sv
module ctrl_reg_ctrl
  import ctrl_reg_pkg::*;
(
  input  logic      wrEn,
  input  crIdx_t    wrIdx,
  input  logic      newMode,
  input  logic      statWrEn,
  input  logic      gprSpWe,
  input  logic      stackMode,
  output crStrobe_t stb
);
  logic liveTaken;

  always_comb begin
    stb = '0;
    if (wrEn) begin
      case (wrIdx)
        IDX_STATUS: begin
          stb.ldStatus = 1'b1;
          if (newMode != stackMode) begin
            if (stackMode) stb.swapEnterIntr = 1'b1;
            else           stb.swapEnterUser = 1'b1;
          end
        end
        IDX_COND:   stb.ldCond = 1'b1;
        IDX_SPI: begin
          if (stackMode) stb.ldSpiSlot = 1'b1;
          else           stb.ldLiveFromBus = 1'b1;
        end
        IDX_SPU: begin
          if (stackMode) stb.ldLiveFromBus = 1'b1;
          else           stb.ldSpuSlot = 1'b1;
        end
        IDX_BPC:    stb.ldBpc = 1'b1;
        IDX_BBSTAT: stb.ldBbStat = 1'b1;
        IDX_BBPC:   stb.ldBbpc = 1'b1;
        default: ;
      endcase
      for (int i = 0; i < GEN_SLOTS; i++) begin
        if (wrIdx == crIdx_t'(IDX_GEN0 + i)) stb.ldGen[i] = 1'b1;
      end
    end
    stb.ldStatusByte = statWrEn && !wrEn;
    liveTaken = stb.ldLiveFromBus || stb.swapEnterIntr || stb.swapEnterUser;
    stb.ldLiveFromGpr = gprSpWe && !liveTaken;
  end
endmodule

// File: rtl/ctrl_reg_datapath.sv
module ctrl_reg_datapath
  import ctrl_reg_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  crStrobe_t         stb,
  input  logic [DATA_W-1:0] wrData,
  input  logic [7:0]        statWrData,
  input  logic [DATA_W-1:0] gprSpData,
  input  crIdx_t            rdIdx,
  output logic [DATA_W-1:0] rdData,
  output logic [7:0]        statRdData,
  output logic [DATA_W-1:0] spLive,
  output logic              stackMode,
  output logic [DATA_W-1:0] spiSlot,
  output logic [DATA_W-1:0] spuSlot
);
  logic [7:0]        bStat, stat, bbStat;
  logic              cond;
  logic [DATA_W-1:0] liveSp, bpc, bbpc;
  logic [DATA_W-1:0] genSlot [GEN_SLOTS];

  always_ff @(posedge clk) begin
    if (rst) begin
      bStat <= '0; stat <= '0; bbStat <= '0; cond <= 1'b0;
      bpc <= '0; bbpc <= '0;
    end else begin
      if (stb.ldStatus) begin
        bStat <= wrData[15:8];
        stat  <= wrData[7:0];
        cond  <= wrData[0];
      end
      if (stb.ldStatusByte) begin
        stat <= statWrData;
        cond <= statWrData[0];
      end
      if (stb.ldCond)   cond   <= wrData[0];
      if (stb.ldBbStat) bbStat <= wrData[7:0];
      if (stb.ldBpc)    bpc    <= wrData;
      if (stb.ldBbpc)   bbpc   <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      liveSp <= '0; spiSlot <= '0; spuSlot <= '0;
    end else begin
      if (stb.ldSpiSlot)          spiSlot <= wrData;
      else if (stb.swapEnterUser) spiSlot <= liveSp;
      if (stb.ldSpuSlot)          spuSlot <= wrData;
      else if (stb.swapEnterIntr) spuSlot <= liveSp;
      if (stb.ldLiveFromBus)      liveSp <= wrData;
      else if (stb.swapEnterIntr) liveSp <= spiSlot;
      else if (stb.swapEnterUser) liveSp <= spuSlot;
      else if (stb.ldLiveFromGpr) liveSp <= gprSpData;
    end
  end

  for (genvar g = 0; g < GEN_SLOTS; g++) begin : gGen
    always_ff @(posedge clk) begin
      if (rst)               genSlot[g] <= '0;
      else if (stb.ldGen[g]) genSlot[g] <= wrData;
    end
  end

  assign stackMode  = stat[MODE_BIT];
  assign statRdData = {stat[7:1], cond};
  assign spLive     = liveSp;

  always_comb begin
    rdData = '0;
    case (rdIdx)
      IDX_STATUS: begin
        rdData[15:8] = bStat & BACKUP_MASK;
        rdData[7:0]  = (stat & STAT_MASK) | {7'b0, cond};
      end
      IDX_COND:   rdData[0] = cond;
      IDX_SPI:    rdData = stackMode ? spiSlot : liveSp;
      IDX_SPU:    rdData = stackMode ? liveSp : spuSlot;
      IDX_BPC:    rdData = {bpc[DATA_W-1:1], 1'b0};
      IDX_BBSTAT: rdData[7:0] = bbStat & BACKUP_MASK;
      IDX_BBPC:   rdData = {bbpc[DATA_W-1:1], 1'b0};
      default: ;
    endcase
    for (int i = 0; i < GEN_SLOTS; i++) begin
      if (rdIdx == crIdx_t'(IDX_GEN0 + i)) rdData = genSlot[i];
    end
  end
endmodule

// File: rtl/ctrl_reg_bank.sv
module ctrl_reg_bank
  import ctrl_reg_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic [DATA_W-1:0] rdData,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [DATA_W-1:0] wrData,
  input  logic              statWrEn,
  input  logic [7:0]        statWrData,
  output logic [7:0]        statRdData,
  input  logic              gprSpWe,
  input  logic [DATA_W-1:0] gprSpData,
  output logic [DATA_W-1:0] spLive
);
  crStrobe_t         stb;
  logic              stackMode;
  logic [DATA_W-1:0] spiSlot, spuSlot;

  ctrl_reg_ctrl uCtrl (
    .wrEn(wrEn), .wrIdx(wrIdx), .newMode(wrData[MODE_BIT]),
    .statWrEn(statWrEn), .gprSpWe(gprSpWe), .stackMode(stackMode), .stb(stb)
  );

  ctrl_reg_datapath #(.DATA_W(DATA_W)) uDp (
    .clk(clk), .rst(rst), .stb(stb), .wrData(wrData), .statWrData(statWrData),
    .gprSpData(gprSpData), .rdIdx(rdIdx), .rdData(rdData), .statRdData(statRdData),
    .spLive(spLive), .stackMode(stackMode), .spiSlot(spiSlot), .spuSlot(spuSlot)
  );
endmodule

// File: rtl/ctrl_reg_bank_chk.sv
module ctrl_reg_bank_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [3:0]        rdIdx,
  input logic [DATA_W-1:0] rdData,
  input logic              wrEn,
  input logic [3:0]        wrIdx,
  input logic [DATA_W-1:0] wrData,
  input logic              statWrEn,
  input logic [7:0]        statWrData,
  input logic [7:0]        statRdData,
  input logic              gprSpWe,
  input logic [DATA_W-1:0] gprSpData,
  input logic [DATA_W-1:0] spLive,
  input logic [DATA_W-1:0] spiSlot,
  input logic [DATA_W-1:0] spuSlot
);
  assert_status_read_R2: assert property (@(posedge clk) disable iff (rst)
    rdIdx == 4'd0 |-> (rdData[DATA_W-1:16] == '0 && rdData[13:9] == '0 &&
      rdData[5:1] == '0 && rdData[7:6] == statRdData[7:6] && rdData[0] == statRdData[0]));

  assert_status_write_R3: assert property (@(posedge clk) disable iff (rst)
    wrEn && wrIdx == 4'd0 |=> statRdData == $past(wrData[7:0]));

  assert_spi_alias_R6: assert property (@(posedge clk) disable iff (rst)
    rdIdx == 4'd2 && !statRdData[7] |-> rdData == spLive);

  assert_spu_alias_R6: assert property (@(posedge clk) disable iff (rst)
    rdIdx == 4'd3 && statRdData[7] |-> rdData == spLive);

  assert_swap_intr_R7: assert property (@(posedge clk) disable iff (rst)
    wrEn && wrIdx == 4'd0 && statRdData[7] && !wrData[7] |=> spLive == $past(spiSlot));

  assert_swap_user_R7: assert property (@(posedge clk) disable iff (rst)
    wrEn && wrIdx == 4'd0 && !statRdData[7] && wrData[7] |=> spLive == $past(spuSlot));

  assert_bpc_lsb_R8: assert property (@(posedge clk) disable iff (rst)
    (rdIdx == 4'd6 || rdIdx == 4'd8) |-> !rdData[0]);

  assert_undef_zero_R9: assert property (@(posedge clk) disable iff (rst)
    rdIdx >= 4'd9 |-> rdData == '0);

  assert_byte_port_R10: assert property (@(posedge clk) disable iff (rst)
    statWrEn && !wrEn && !gprSpWe |=> statRdData == $past(statWrData) && $stable(spLive));

  assert_gpr_write_R11: assert property (@(posedge clk) disable iff (rst)
    gprSpWe && !wrEn |=> spLive == $past(gprSpData));
endmodule

bind ctrl_reg_bank ctrl_reg_bank_chk #(.DATA_W(DATA_W)) uChk (
  .clk(clk), .rst(rst), .rdIdx(rdIdx), .rdData(rdData), .wrEn(wrEn), .wrIdx(wrIdx),
  .wrData(wrData), .statWrEn(statWrEn), .statWrData(statWrData),
  .statRdData(statRdData), .gprSpWe(gprSpWe), .gprSpData(gprSpData),
  .spLive(spLive), .spiSlot(uDp.spiSlot), .spuSlot(uDp.spuSlot)
);

// File: tb/test_ctrl_reg_bank.sv
`timescale 1ns/1ps
module test_ctrl_reg_bank;
  logic        clk = 1'b0;
  logic        rst;
  logic [3:0]  rdIdx, wrIdx;
  logic [31:0] rdData, wrData, gprSpData, spLive;
  logic        wrEn, statWrEn, gprSpWe;
  logic [7:0]  statWrData, statRdData;

  int testCount = 0;
  int failCount = 0;
  bit finished  = 0;

  // behavioural reference state
  logic [7:0]  mStat, mBstat, mBb;
  logic        mCond;
  logic [31:0] mSpi, mSpu, mLive, mBpc, mBbpc, mGen4, mGen5;

  always #2 clk = ~clk;

  ctrl_reg_bank i_ctrl_reg_bank (
    .clk(clk), .rst(rst), .rdIdx(rdIdx), .rdData(rdData), .wrEn(wrEn), .wrIdx(wrIdx),
    .wrData(wrData), .statWrEn(statWrEn), .statWrData(statWrData),
    .statRdData(statRdData), .gprSpWe(gprSpWe), .gprSpData(gprSpData), .spLive(spLive)
  );

  function automatic logic [31:0] expRead(input logic [3:0] idx);
    case (idx)
      4'd0: return {16'b0, mBstat & 8'hC1, (mStat & 8'hC0) | {7'b0, mCond}};
      4'd1: return {31'b0, mCond};
      4'd2: return mStat[7] ? mSpi : mLive;
      4'd3: return mStat[7] ? mLive : mSpu;
      4'd4: return mGen4;
      4'd5: return mGen5;
      4'd6: return mBpc & 32'hFFFF_FFFE;
      4'd7: return {24'b0, mBb & 8'hC1};
      4'd8: return mBbpc & 32'hFFFF_FFFE;
      default: return 32'b0;
    endcase
  endfunction

  task automatic modelEdge();
    bit touched = 0;
    if (rst) begin
      mStat = 0; mBstat = 0; mBb = 0; mCond = 0;
      mSpi = 0; mSpu = 0; mLive = 0; mBpc = 0; mBbpc = 0; mGen4 = 0; mGen5 = 0;
      return;
    end
    if (wrEn) begin
      case (wrIdx)
        4'd0: begin
          if (mStat[7] && !wrData[7]) begin
            mSpu = mLive; mLive = mSpi; touched = 1;
          end else if (!mStat[7] && wrData[7]) begin
            mSpi = mLive; mLive = mSpu; touched = 1;
          end
          mBstat = wrData[15:8]; mStat = wrData[7:0]; mCond = wrData[0];
        end
        4'd1: mCond = wrData[0];
        4'd2: if (mStat[7]) mSpi = wrData; else begin mLive = wrData; touched = 1; end
        4'd3: if (mStat[7]) begin mLive = wrData; touched = 1; end else mSpu = wrData;
        4'd4: mGen4 = wrData;
        4'd5: mGen5 = wrData;
        4'd6: mBpc = wrData;
        4'd7: mBb = wrData[7:0];
        4'd8: mBbpc = wrData;
        default: ;
      endcase
    end else if (statWrEn) begin
      mStat = statWrData; mCond = statWrData[0];
    end
    if (gprSpWe && !touched) mLive = gprSpData;
  endtask

  task automatic compare(input string tag);
    logic [31:0] eRd = expRead(rdIdx);
    logic [7:0]  eSt = {mStat[7:1], mCond};
    testCount++;
    if (rdData !== eRd || statRdData !== eSt || spLive !== mLive) begin
      failCount++;
      $display("FAIL %s idx=%0d rd=%h/%h stat=%h/%h sp=%h/%h (actual/expected)",
               tag, rdIdx, rdData, eRd, statRdData, eSt, spLive, mLive);
    end
  endtask

  task automatic step(input string tag, input logic [3:0] ri,
                      input logic we, input logic [3:0] wi, input logic [31:0] wd,
                      input logic swe = 0, input logic [7:0] sd = 0,
                      input logic gwe = 0, input logic [31:0] gd = 0);
    rdIdx = ri; wrEn = we; wrIdx = wi; wrData = wd;
    statWrEn = swe; statWrData = sd; gprSpWe = gwe; gprSpData = gd;
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    compare(tag);
  endtask

  task automatic rd(input string tag, input logic [3:0] ri);
    step(tag, ri, 0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failCount++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

  initial begin
    rst = 1;
    step("R1", 0, 1, 0, 32'hFFFF_FFFF, 1, 8'hFF, 1, 32'h1234);
    step("R1", 0, 0, 0, 0);
    rst = 0;
    for (int i = 0; i < 16; i++) rd("R1", i[3:0]);

    step("R11", 2, 0, 0, 0, 0, 0, 1, 32'h0000_1000);
    step("R6", 2, 1, 4'd2, 32'h2222_2222);
    step("R6", 3, 1, 4'd3, 32'h3333_3333);
    rd("R6", 2);
    step("R7", 2, 1, 4'd0, 32'h0000_0080);
    rd("R7", 3);
    step("R6", 2, 1, 4'd2, 32'h4444_4444);
    step("R6", 3, 1, 4'd3, 32'h5555_5555);
    step("R7", 3, 1, 4'd0, 32'h0000_0081);
    step("R7", 2, 1, 4'd0, 32'h0000_0000);
    rd("R7", 3);

    step("R3", 0, 1, 4'd0, 32'hFFFF_FF7F);
    rd("R2", 0);
    step("R3", 0, 1, 4'd0, 32'h0000_3E40);
    step("R2", 0, 1, 4'd0, 32'h0000_C1C1);
    step("R4", 1, 1, 4'd1, 32'h0000_0003);
    step("R4", 1, 1, 4'd1, 32'hFFFF_FFFE);
    step("R5", 7, 1, 4'd7, 32'hFFFF_FFFF);
    step("R5", 7, 1, 4'd7, 32'h0000_1234);
    step("R8", 6, 1, 4'd6, 32'hDEAD_BEEF);
    step("R8", 8, 1, 4'd8, 32'h1357_9BDF);
    step("R9", 4, 1, 4'd4, 32'hA5A5_0001);
    step("R9", 5, 1, 4'd5, 32'h5A5A_0003);
    for (int i = 9; i < 16; i++) step("R9", i[3:0], 1, i[3:0], 32'hFFFF_FFFF);
    for (int i = 0; i < 16; i++) rd("R9", i[3:0]);

    step("R10", 2, 0, 0, 0, 1, 8'h83);
    rd("R10", 3);
    step("R10", 0, 0, 0, 0, 1, 8'h3E);
    step("R11", 2, 1, 4'd0, 32'h0000_0080, 0, 0, 1, 32'hBAD0_BAD0);
    step("R11", 3, 1, 4'd3, 32'h7777_7777, 0, 0, 1, 32'hBAD1_BAD1);
    step("R11", 3, 1, 4'd6, 32'h0000_0100, 0, 0, 1, 32'h8888_8888);
    step("R11", 2, 1, 4'd2, 32'h9999_9999, 0, 0, 1, 32'h6666_6666);
    step("R12", 0, 1, 4'd0, 32'h0000_0081, 1, 8'h00);
    step("R12", 4, 1, 4'd4, 32'h0BAD_F00D, 1, 8'h7E);

    for (int n = 0; n < 600; n++) begin
      logic [31:0] r = $urandom;
      step("RND", r[3:0], r[4], r[8:5], (r[9] ? {24'b0, r[31:24] ^ 8'h80} : $urandom),
           r[10] & r[11], r[19:12], r[20] & r[21], $urandom);
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule